// File: doc/BRIEF.md
# Barrel Shifter with Exponent and Normalization Unit

This block is the shift stage of a 16-bit fixed-point datapath. It places a 16-bit input word in either half of a 32-bit field and shifts that field. The shift can be logical or arithmetic, and either left or right by a signed amount. The result can be ORed into the previous result, so a 32-bit value can be assembled or shifted in two passes.

Besides plain shifts, the block derives the exponent of a word. The exponent is the negated count of its redundant sign bits. A variant uses a carry bit as an extra sign bit above the word, which covers overflowed sums. Normalize and denormalize operations take an exponent as their shift amount. A block-exponent register keeps the largest exponent seen over a series of words, which serves block floating point.

Each operation is selected by a 3-bit code qualified by a valid strobe. Every output is registered and shows the effect of an operation one clock after it is presented.

Top module: `shift_norm_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `resultOut` is 0, `expOut` is 0 and `blkExpOut` is -15 (8'hF1).
- R2: An operation presented with `opValid` high updates the outputs at the next rising clock edge. With `opValid` low, all three outputs keep their values.
- R3: Code 0 is a logical shift by the signed 8-bit `shiftAmt`.
  - A positive amount shifts left and a negative amount shifts right.
  - Vacated bits are filled with zero.
  - A magnitude of 32 or more gives 0.
- R4: Code 1 is an arithmetic shift by the signed `shiftAmt`.
  - Left shifts behave as in code 0.
  - Right shifts fill with bit 31 of the placed field.
  - A right shift by 32 or more gives 32 copies of that bit.
- R5: Before shifting, the input is placed in the 32-bit field as follows:
  - `hiSel`=1 puts it at bits 31..16, with the low half zero.
  - `hiSel`=0 puts it at bits 15..0.
  - With `hiSel`=0, the upper half is zero for codes 0 and 2, and a copy of input bit 15 for codes 1 and 3.
- R6: For codes 0 to 3, `orMode`=1 makes the new result the shifted field ORed with the previous `resultOut`. `orMode`=0 replaces the previous result.
- R7: Code 2 (normalize) shifts logically left by the magnitude of `shiftAmt`, ignoring its sign.
- R8: Code 3 (denormalize) shifts arithmetically right by the magnitude of `shiftAmt`, ignoring its sign.
- R9: Code 4 sets `expOut` to minus the number of bits, counted from bit 14 downward, that equal bit 15 before the first bit that differs. The value lies in 0 to -15 and is given in 8-bit two's complement.
- R10: Code 5 sets `expOut` to 1 minus the run of bits, counted from bit 15 downward, that equal `carryIn`. The value is +1 when bit 15 differs from `carryIn`, and the range is +1 to -15.
- R11: Code 6 computes the code-4 exponent of `dataIn` and loads it into `blkExpOut` only if it is greater than the current value.
- R12: Code 7 sets `blkExpOut` to -15.
- R13: Codes 4 to 7 leave `resultOut` unchanged. Codes 0 to 3, 6 and 7 leave `expOut` unchanged. Codes 0 to 5 leave `blkExpOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Qualifies the operation on this cycle |
| opCode | input | 3 | Operation select, codes 0 to 7 |
| dataIn | input | 16 | Input data word |
| shiftAmt | input | 8 | Signed shift amount or exponent |
| hiSel | input | 1 | Place the input in the high half (1) or the low half (0) |
| orMode | input | 1 | OR the new result with the previous result |
| carryIn | input | 1 | Extra sign bit used by code 5 |
| resultOut | output | 32 | Registered 32-bit shift result |
| expOut | output | 8 | Registered derived exponent, two's complement |
| blkExpOut | output | 8 | Registered block exponent, two's complement |

## Verification
On every cycle, the assertions check the following:
- Outputs hold through idle cycles.
- Exponent operations leave the result alone.
- The exponent stays within +1 to -15.
- The block exponent never falls except on a clear, and a clear lands on -15.
- A zero word yields -15.
- Over-range logical shifts give zero.

The exact bit patterns can only be shown by the bench scenarios, which compare against an independent bit-by-bit model. These scenarios cover fill values for each direction and mode, placement in either half, two-pass OR assembly, exponents of boundary words with and without the carry bit, and the running maximum over a word series.

// File: rtl/shiftnorm_pkg.sv
package shiftnorm_pkg;

  typedef enum logic [2:0] {
    OP_LSH    = 3'd0,
    OP_ASH    = 3'd1,
    OP_NORM   = 3'd2,
    OP_DENORM = 3'd3,
    OP_EXP    = 3'd4,
    OP_EXPHI  = 3'd5,
    OP_BLKEXP = 3'd6,
    OP_BLKRST = 3'd7
  } snuOp_e;

  typedef enum logic [1:0] {
    AMT_SIGNED = 2'd0,
    AMT_LEFT   = 2'd1,
    AMT_RIGHT  = 2'd2
  } amtMode_e;

  typedef struct packed {
    logic     ldRes;
    logic     ldExp;
    logic     ldBlk;
    logic     clrBlk;
    logic     arith;
    logic     signExt;
    logic     hiExt;
    amtMode_e amtMode;
  } snuStrobes_t;

endpackage

// File: rtl/snu_ctrl.sv
module snu_ctrl
  import shiftnorm_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opCode,
  output snuStrobes_t strobes
);

  snuOp_e op;
  assign op = snuOp_e'(opCode);

  always_comb begin
    strobes = '{ldRes: 1'b0, ldExp: 1'b0, ldBlk: 1'b0, clrBlk: 1'b0,
                arith: 1'b0, signExt: 1'b0, hiExt: 1'b0, amtMode: AMT_SIGNED};
    if (opValid) begin
      unique case (op)
        OP_LSH: strobes.ldRes = 1'b1;
        OP_ASH: begin
          strobes.ldRes   = 1'b1;
          strobes.arith   = 1'b1;
          strobes.signExt = 1'b1;
        end
        OP_NORM: begin
          strobes.ldRes   = 1'b1;
          strobes.amtMode = AMT_LEFT;
        end
        OP_DENORM: begin
          strobes.ldRes   = 1'b1;
          strobes.arith   = 1'b1;
          strobes.signExt = 1'b1;
          strobes.amtMode = AMT_RIGHT;
        end
        OP_EXP: strobes.ldExp = 1'b1;
        OP_EXPHI: begin
          strobes.ldExp = 1'b1;
          strobes.hiExt = 1'b1;
        end
        OP_BLKEXP: strobes.ldBlk = 1'b1;
        OP_BLKRST: strobes.clrBlk = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/snu_signrun.sv
module snu_signrun #(
  parameter int W     = 16,
  parameter int RUN_W = $clog2(W + 1)
) (
  input  logic [W:0]       word,
  output logic [RUN_W-1:0] run
);

  logic stop;

  always_comb begin
    run  = '0;
    stop = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!stop && (word[i] == word[W])) run = run + RUN_W'(1);
      else stop = 1'b1;
    end
  end

endmodule

// File: rtl/snu_datapath.sv
module snu_datapath
  import shiftnorm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int EXP_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  snuStrobes_t           strobes,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [AMT_W-1:0]      shiftAmt,
  input  logic                  hiSel,
  input  logic                  orMode,
  input  logic                  carryIn,
  output logic [2*DATA_W-1:0]   resultOut,
  output logic [EXP_W-1:0]      expOut,
  output logic [EXP_W-1:0]      blkExpOut
);

  localparam int OUT_W = 2 * DATA_W;
  localparam int CNT_W = AMT_W + 1;
  localparam int RUN_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] OUT_LIM   = CNT_W'(OUT_W);
  localparam logic [EXP_W-1:0] BLK_FLOOR = EXP_W'(1 - DATA_W);

  logic [OUT_W-1:0]        placed, shifted, resReg;
  logic signed [CNT_W-1:0] amtExt, amtMag, cnt;
  logic [CNT_W-1:0]        lCnt, rCnt;
  logic [DATA_W:0]         runWord;
  logic [RUN_W-1:0]        run;
  logic [EXP_W-1:0]        expVal, expReg, blkReg;

  // placement of the input word inside the wide field
  always_comb begin
    if (hiSel) placed = {dataIn, {DATA_W{1'b0}}};
    else       placed = {{DATA_W{strobes.signExt & dataIn[DATA_W-1]}}, dataIn};
  end

  // shift count selection
  always_comb begin
    amtExt = {shiftAmt[AMT_W-1], shiftAmt};
    amtMag = amtExt[CNT_W-1] ? -amtExt : amtExt;
    unique case (strobes.amtMode)
      AMT_LEFT:  cnt = amtMag;
      AMT_RIGHT: cnt = -amtMag;
      default:   cnt = amtExt;
    endcase
    lCnt = cnt;
    rCnt = -cnt;
  end

  // barrel shift with saturation for counts beyond the field
  always_comb begin
    if (!cnt[CNT_W-1]) begin
      shifted = (lCnt >= OUT_LIM) ? '0 : (placed << lCnt);
    end else if (rCnt >= OUT_LIM) begin
      shifted = strobes.arith ? {OUT_W{placed[OUT_W-1]}} : '0;
    end else if (strobes.arith) begin
      shifted = OUT_W'($signed(placed) >>> rCnt);
    end else begin
      shifted = placed >> rCnt;
    end
  end

  // exponent derivation
  assign runWord = {(strobes.hiExt ? carryIn : dataIn[DATA_W-1]), dataIn};

  snu_signrun #(.W(DATA_W), .RUN_W(RUN_W)) i_signRun (
    .word (runWord),
    .run  (run)
  );

  assign expVal = EXP_W'(1) - EXP_W'(run);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
      expReg <= '0;
      blkReg <= BLK_FLOOR;
    end else begin
      if (strobes.ldRes) resReg <= shifted | (orMode ? resReg : '0);
      if (strobes.ldExp) expReg <= expVal;
      if (strobes.clrBlk) blkReg <= BLK_FLOOR;
      else if (strobes.ldBlk && ($signed(expVal) > $signed(blkReg))) blkReg <= expVal;
    end
  end

  assign resultOut = resReg;
  assign expOut    = expReg;
  assign blkExpOut = blkReg;

endmodule

// File: rtl/shift_norm_unit.sv
module shift_norm_unit
  import shiftnorm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int EXP_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opCode,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [AMT_W-1:0]    shiftAmt,
  input  logic                hiSel,
  input  logic                orMode,
  input  logic                carryIn,
  output logic [2*DATA_W-1:0] resultOut,
  output logic [EXP_W-1:0]    expOut,
  output logic [EXP_W-1:0]    blkExpOut
);

  snuStrobes_t strobes;

  snu_ctrl i_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  snu_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W), .EXP_W(EXP_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .shiftAmt  (shiftAmt),
    .hiSel     (hiSel),
    .orMode    (orMode),
    .carryIn   (carryIn),
    .resultOut (resultOut),
    .expOut    (expOut),
    .blkExpOut (blkExpOut)
  );

endmodule

// File: rtl/snu_checker.sv
module snu_checker #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 8,
  parameter int EXP_W  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opCode,
  input logic [DATA_W-1:0]   dataIn,
  input logic [AMT_W-1:0]    shiftAmt,
  input logic                orMode,
  input logic [2*DATA_W-1:0] resultOut,
  input logic [EXP_W-1:0]    expOut,
  input logic [EXP_W-1:0]    blkExpOut
);

  localparam int EXP_MIN = 1 - DATA_W;
  localparam int OUT_W   = 2 * DATA_W;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(resultOut) && $stable(expOut) && $stable(blkExpOut)));

  // R13
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[2]) |=> $stable(resultOut));

  // R10
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(expOut) <= 1) && ($signed(expOut) >= EXP_MIN));

  // R11
  blk_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode != 3'd7)) |=> ($signed(blkExpOut) >= $signed($past(blkExpOut))));

  // R12
  blk_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd7)) |=> ($signed(blkExpOut) == EXP_MIN));

  // R9
  exp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd4) && (dataIn == '0)) |=> ($signed(expOut) == EXP_MIN));

  // R3
  lsh_far_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 3'd0) && !orMode && ($signed(shiftAmt) >= OUT_W)) |=> (resultOut == '0));

endmodule

bind shift_norm_unit snu_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W), .EXP_W(EXP_W)) i_snuChk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .dataIn    (dataIn),
  .shiftAmt  (shiftAmt),
  .orMode    (orMode),
  .resultOut (resultOut),
  .expOut    (expOut),
  .blkExpOut (blkExpOut)
);

// File: tb/test_shift_norm_unit.sv
`timescale 1ns/1ps
module test_shift_norm_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [15:0] dataIn = '0;
  logic [7:0]  shiftAmt = '0;
  logic        hiSel = 1'b0;
  logic        orMode = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic [7:0]  expOut;
  logic [7:0]  blkExpOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mRes = '0;
  logic [7:0]  mExp = '0;
  logic [7:0]  mBlk = 8'hF1;

  logic [31:0] qRes[$];
  logic [7:0]  qExp[$];
  logic [7:0]  qBlk[$];
  string       qTag[$];

  always #2 clk = ~clk;

  shift_norm_unit i_shift_norm_unit (
    .clk, .rstN, .opValid, .opCode, .dataIn, .shiftAmt, .hiSel,
    .orMode, .carryIn, .resultOut, .expOut, .blkExpOut
  );

  function automatic logic [31:0] mShift(logic [31:0] v, int c, bit ar);
    for (int i = 0; i < c && i < 40; i++) v = {v[30:0], 1'b0};
    for (int i = 0; i < -c && i < 40; i++) v = {(ar ? v[31] : 1'b0), v[31:1]};
    return v;
  endfunction

  function automatic int mRun(logic s, logic [15:0] d);
    int  n = 0;
    bit  go = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      if (go && d[i] == s) n++;
      else go = 1'b0;
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation and pushes the expected outputs
  task automatic doOp(bit v, int op, logic [15:0] d, int a, bit hi, bit orm, bit cin, string tag);
    logic [31:0] placed;
    int mag, c, e;
    bit ar;
    @(negedge clk);
    opValid = v; opCode = 3'(op); dataIn = d; shiftAmt = 8'(a);
    hiSel = hi; orMode = orm; carryIn = cin;
    if (v) begin
      mag = (a < 0) ? -a : a;
      placed = hi ? {d, 16'h0} : {((op == 1 || op == 3) ? {16{d[15]}} : 16'h0), d};
      c = a; ar = 1'b0;
      case (op)
        1: ar = 1'b1;
        2: c = mag;
        3: begin c = -mag; ar = 1'b1; end
        default: ;
      endcase
      if (op <= 3) mRes = mShift(placed, c, ar) | (orm ? mRes : 32'h0);
      if (op == 4) mExp = 8'(1 - mRun(d[15], d));
      if (op == 5) mExp = 8'(1 - mRun(cin, d));
      if (op == 6) begin
        e = 1 - mRun(d[15], d);
        if (e > int'($signed(mBlk))) mBlk = 8'(e);
      end
      if (op == 7) mBlk = 8'hF1;
    end
    qRes.push_back(mRes); qExp.push_back(mExp); qBlk.push_back(mBlk); qTag.push_back(tag);
  endtask

  // monitor: compares each expected item one edge after its operation
  always @(posedge clk) begin
    #1;
    if (qTag.size() > 0) begin
      automatic string t = qTag.pop_front();
      chk(t, "result", resultOut, qRes.pop_front());
      chk(t, "exp", {24'h0, expOut}, {24'h0, qExp.pop_front()});
      chk(t, "blk", {24'h0, blkExpOut}, {24'h0, qBlk.pop_front()});
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk("R1", "result", resultOut, 32'h0);
    chk("R1", "blk", {24'h0, blkExpOut}, 32'hF1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "exp", {24'h0, expOut}, 32'h0);

    doOp(1, 0, 16'h00F3, 4, 0, 0, 0, "R3 left");
    doOp(1, 0, 16'h8001, -4, 1, 0, 0, "R3 right");
    doOp(1, 0, 16'hFFFF, 32, 1, 0, 0, "R3 far left");
    doOp(1, 0, 16'hFFFF, -40, 1, 0, 0, "R3 far right");
    doOp(1, 1, 16'h8421, -4, 1, 0, 0, "R4 right");
    doOp(1, 1, 16'h8000, -100, 1, 0, 0, "R4 far right");
    doOp(1, 1, 16'h4001, 3, 1, 0, 0, "R4 left");
    doOp(1, 1, 16'hF00F, -1, 0, 0, 0, "R5 lo signext");
    doOp(1, 0, 16'hF00F, 0, 0, 0, 0, "R5 lo zero");
    doOp(1, 0, 16'h1234, 0, 1, 0, 0, "R6 pass1");
    doOp(1, 0, 16'h5678, 0, 0, 1, 0, "R6 pass2");
    doOp(1, 0, 16'h00FF, 8, 0, 1, 0, "R6 or shift");
    doOp(1, 2, 16'h0F0F, -3, 1, 0, 0, "R7 neg amt");
    doOp(1, 2, 16'h0F0F, 3, 0, 0, 0, "R7 pos amt");
    doOp(1, 3, 16'hC000, 2, 1, 0, 0, "R8 pos amt");
    doOp(1, 3, 16'h8000, -5, 0, 0, 0, "R8 neg amt");
    doOp(0, 0, 16'hFFFF, 1, 1, 0, 0, "R2 idle");
    doOp(1, 4, 16'h0000, 0, 0, 0, 0, "R9 zero");
    doOp(1, 4, 16'hFFFF, 0, 0, 0, 0, "R9 ones");
    doOp(1, 4, 16'h4000, 0, 0, 0, 0, "R9 top");
    doOp(1, 4, 16'h1000, 0, 0, 0, 0, "R9 mid");
    doOp(1, 4, 16'hE7FF, 0, 0, 0, 0, "R9 neg");
    doOp(1, 5, 16'h7FFF, 0, 0, 0, 1, "R10 overflow");
    doOp(1, 5, 16'h0FFF, 0, 0, 0, 0, "R10 run");
    doOp(1, 5, 16'hFFFF, 0, 0, 0, 1, "R10 full");
    doOp(1, 7, 16'h0000, 0, 0, 0, 0, "R12 clear");
    doOp(1, 6, 16'h0100, 0, 0, 0, 0, "R11 first");
    doOp(1, 6, 16'h0800, 0, 0, 0, 0, "R11 larger");
    doOp(1, 6, 16'h0010, 0, 0, 0, 0, "R11 smaller");
    doOp(1, 6, 16'hFC00, 0, 0, 0, 0, "R11 neg");
    doOp(1, 0, 16'h0000, 0, 0, 1, 0, "R13 shift keeps exp");
    doOp(1, 7, 16'hFFFF, 5, 1, 0, 0, "R12 clear again");
    doOp(0, 7, 16'h0000, 0, 0, 0, 0, "R2 idle tail");
    while (qTag.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule